// File: doc/BRIEF.md
# Two-Wire Bus Condition Detector

This block sits between the raw clock and data pins of a two-wire serial slave and the protocol engine behind it. Both lines arrive unsynchronized. Each passes through a two-flop synchronizer and then a saturating-count filter. The filter accepts a new level only after that level has been seen on a fixed number of consecutive system clocks, so short spikes on either wire never reach the decoder.

From the two cleaned levels the block derives one-cycle event strobes. A start is the data line dropping while the clock line is high. A stop is the data line rising while the clock line is high. The block also flags clock rising and clock falling edges, and it captures the data level at each clock rise. A busy flag covers the span from a start to the next stop.

On the transmit side the protocol engine asks for the data-line pull-down through a request input. The block forwards that request to the pad enable, but holds the enable frozen for a minimum time after every filtered clock fall. This keeps the slave from moving the data line inside the slow falling edge of the clock, where it could look like a start or stop. Filter length and hold time come from the system clock period, the spike width and the hold time, all given in nanoseconds as parameters.

Top module: `twi_cond_detect`

## Requirements
- R1: During and after synchronous reset, start_o, stop_o, scl_rise_o and scl_fall_o are 0. bit_o is 1, busy_o is 0 and sda_oe_o is 0. The filtered lines start high (idle).
- R2: A change on either input that lasts fewer than FILT_LEN consecutive clocks produces no strobe. FILT_LEN = SPIKE_NS/CLK_PERIOD_NS + 2, which is 7 with the defaults. A change held for FILT_LEN clocks is accepted.
- R3: A strobe caused by an input change is high in the cycle after the (FILT_LEN+2)-th rising clock edge that follows the change, and not before.
- R4: The filtered data line falling while the filtered clock line is high gives start_o high for exactly one cycle.
- R5: The filtered data line rising while the filtered clock line is high gives stop_o high for exactly one cycle.
- R6: A filtered clock rise gives scl_rise_o for one cycle. A filtered clock fall gives scl_fall_o for one cycle. At a clock rise, bit_o loads the filtered data level and then holds it until the next reported rise.
- R7: When a filtered data change lands in the same cycle as a filtered clock rise, the block reports start or stop, suppresses scl_rise_o and leaves bit_o unchanged.
- R8: busy_o is set in the cycle after start_o and cleared in the cycle after stop_o. A start while busy leaves it set.
- R9: When no hold is active, sda_oe_o takes the value of oe_req_i on the next clock edge. After scl_fall_o, sda_oe_o stays unchanged for HOLD_CYC+1 edges and takes the request on the (HOLD_CYC+2)-th edge. HOLD_CYC = ceil(HOLD_NS/CLK_PERIOD_NS), which is 30 with the defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw asynchronous clock-line level |
| sda_i | input | 1 | Raw asynchronous data-line level |
| oe_req_i | input | 1 | Requested data-line pull-down from the protocol engine |
| start_o | output | 1 | One-cycle start event |
| stop_o | output | 1 | One-cycle stop event |
| scl_rise_o | output | 1 | One-cycle filtered clock rising edge |
| scl_fall_o | output | 1 | One-cycle filtered clock falling edge |
| bit_o | output | 1 | Data level captured at the last reported clock rise |
| busy_o | output | 1 | High between a start and the following stop |
| sda_oe_o | output | 1 | Hold-gated data-line pull-down enable |

## Verification
The assertions check on every cycle the following properties:
- a filtered level changes only to a value its synchronizer showed;
- start and stop never last two cycles;
- a start or stop leaves the captured bit alone;
- the busy flag tracks both events;
- the pad enable never moves while the hold counter runs or in the cycle of a clock fall.

Only the bench scenarios can show the rest:
- the exact latency through synchronizer and filter;
- the boundary between a spike of FILT_LEN-1 clocks and a pulse of FILT_LEN clocks;
- the priority outcome when both lines move together;
- the precise edge on which a held enable finally updates.

// File: rtl/twi_cond_pkg.sv
package twi_cond_pkg;

    // Consecutive agreeing samples needed before a filtered line may change.
    function automatic int unsigned filt_len_f(input int unsigned clk_ns,
                                               input int unsigned spike_ns);
        return spike_ns / clk_ns + 2;
    endfunction

    // Clocks the pad enable stays frozen after a filtered clock fall.
    function automatic int unsigned hold_cyc_f(input int unsigned clk_ns,
                                               input int unsigned hold_ns);
        return (hold_ns + clk_ns - 1) / clk_ns;
    endfunction

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

endpackage

// File: rtl/line_filter.sv
module line_filter #(
    parameter int unsigned FILT_LEN = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o
);
    localparam int unsigned CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(FILT_LEN - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            cnt_q   <= '0;
            level_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_TOP) begin
                cnt_q   <= '0;
                level_q <= sync_q[1];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign level_o = level_q;

    AST_FILT_AGREE: assert property (@(posedge clk) disable iff (rst)
        (level_q != $past(level_q)) |-> ($past(sync_q[1]) == level_q)); // R2

endmodule

// File: rtl/cond_detect.sv
module cond_detect
    import twi_cond_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_f_i,
    input  logic     sda_f_i,
    output bus_evt_t evt_o,
    output logic     bit_o,
    output logic     busy_o
);
    logic scl_q, sda_q, bit_q, busy_q;
    bus_evt_t evt;

    always_comb begin
        evt.start = scl_f_i & sda_q & ~sda_f_i;
        evt.stop  = scl_f_i & ~sda_q & sda_f_i;
        evt.rise  = scl_f_i & ~scl_q & ~(evt.start | evt.stop);
        evt.fall  = ~scl_f_i & scl_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            bit_q  <= 1'b1;
            busy_q <= 1'b0;
        end else begin
            scl_q <= scl_f_i;
            sda_q <= sda_f_i;
            if (evt.rise)
                bit_q <= sda_f_i;
            if (evt.start)
                busy_q <= 1'b1;
            else if (evt.stop)
                busy_q <= 1'b0;
        end
    end

    assign evt_o  = evt;
    assign bit_o  = bit_q;
    assign busy_o = busy_q;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> !evt.start); // R4
    AST_STOP_PULSE: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !evt.stop); // R5
    AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        evt.rise |=> (bit_q == $past(sda_f_i))); // R6
    AST_EVT_KEEPS_BIT: assert property (@(posedge clk) disable iff (rst)
        (evt.start || evt.stop) |=> $stable(bit_q)); // R7
    AST_BUSY_SET: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> busy_q); // R8
    AST_BUSY_CLR: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !busy_q); // R8

endmodule

// File: rtl/tx_hold.sv
module tx_hold #(
    parameter int unsigned HOLD_CYC = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_i,
    input  logic oe_req_i,
    output logic oe_o
);
    localparam int unsigned CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(HOLD_CYC);

    logic [CW-1:0] cnt_q;
    logic          oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            oe_q  <= 1'b0;
        end else if (fall_i) begin
            cnt_q <= CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else begin
            oe_q <= oe_req_i;
        end
    end

    assign oe_o = oe_q;

    AST_HOLD_OE: assert property (@(posedge clk) disable iff (rst)
        (fall_i || cnt_q != '0) |=> $stable(oe_q)); // R9
    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (rst)
        fall_i |=> (cnt_q == CNT_LOAD)); // R9

endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect
    import twi_cond_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned SPIKE_NS      = 50,
    parameter int unsigned HOLD_NS       = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic oe_req_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic bit_o,
    output logic busy_o,
    output logic sda_oe_o
);
    localparam int unsigned FILT_LEN = filt_len_f(CLK_PERIOD_NS, SPIKE_NS);
    localparam int unsigned HOLD_CYC = hold_cyc_f(CLK_PERIOD_NS, HOLD_NS);

    logic [1:0] raw_w;
    logic [1:0] filt_w;
    bus_evt_t   evt_w;

    assign raw_w = {scl_i, sda_i};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_line
            line_filter #(.FILT_LEN(FILT_LEN)) filt_i (
                .clk    (clk),
                .rst    (rst),
                .raw_i  (raw_w[g]),
                .level_o(filt_w[g])
            );
        end
    endgenerate

    cond_detect cond_i (
        .clk    (clk),
        .rst    (rst),
        .scl_f_i(filt_w[1]),
        .sda_f_i(filt_w[0]),
        .evt_o  (evt_w),
        .bit_o  (bit_o),
        .busy_o (busy_o)
    );

    tx_hold #(.HOLD_CYC(HOLD_CYC)) hold_i (
        .clk     (clk),
        .rst     (rst),
        .fall_i  (evt_w.fall),
        .oe_req_i(oe_req_i),
        .oe_o    (sda_oe_o)
    );

    assign start_o    = evt_w.start;
    assign stop_o     = evt_w.stop;
    assign scl_rise_o = evt_w.rise;
    assign scl_fall_o = evt_w.fall;

    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> !(start_o || stop_o || scl_rise_o || scl_fall_o)); // R1

endmodule

// File: tb/twi_cond_detect_tb_top.sv
module twi_cond_detect_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FILT_LEN   = 50 / CLK_PERIOD + 2;
    localparam int HOLD_CYC   = (300 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int LAT        = FILT_LEN + 2;

    // {scl, sda, start, stop, rise, fall, bit_after, busy_after}
    localparam logic [7:0] VEC [14] = '{
        8'b10_1000_11, 8'b00_0001_11, 8'b01_0000_11, 8'b11_0010_11,
        8'b01_0001_11, 8'b00_0000_11, 8'b10_0010_01, 8'b11_0100_00,
        8'b10_1000_01, 8'b00_0001_01, 8'b01_0000_01, 8'b10_1000_01,
        8'b00_0001_01, 8'b11_0100_00
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_i = 1'b1, sda_i = 1'b1, oe_req_i = 1'b0;
    logic start_o, stop_o, scl_rise_o, scl_fall_o, bit_o, busy_o, sda_oe_o;

    int checks = 0;
    int errors = 0;
    int n_start = 0, n_stop = 0, n_fall = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    twi_cond_detect dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .oe_req_i(oe_req_i),
        .start_o(start_o), .stop_o(stop_o), .scl_rise_o(scl_rise_o),
        .scl_fall_o(scl_fall_o), .bit_o(bit_o), .busy_o(busy_o), .sda_oe_o(sda_oe_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            n_start += int'(start_o);
            n_stop  += int'(stop_o);
            n_fall  += int'(scl_fall_o);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] strobes();
        return {start_o, stop_o, scl_rise_o, scl_fall_o};
    endfunction

    task automatic wait_pos(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sda_pulse(input int len);
        @(negedge clk) sda_i = 1'b0;
        repeat (len) @(posedge clk);
        @(negedge clk) sda_i = 1'b1;
        wait_pos(3 * LAT);
    endtask

    initial begin
        int s0, p0, f0;
        // R1 reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 strobes in reset", int'(strobes()), 0);
        rst = 1'b0;
        wait_pos(LAT + 2);
        chk("R1 strobes idle", int'(strobes()), 0);
        chk("R1 bit_o", int'(bit_o), 1);
        chk("R1 busy_o", int'(busy_o), 0);
        chk("R1 sda_oe_o", int'(sda_oe_o), 0);

        // Table: R3 latency, R4/R5/R6 events, R7 priority, R8 busy
        for (int v = 0; v < 14; v++) begin
            logic [7:0] e;
            e = VEC[v];
            scl_i = e[7];
            sda_i = e[6];
            wait_pos(LAT - 1);
            chk("R3 no early strobe", int'(strobes()), 0);
            wait_pos(1);
            chk("R4 R5 R6 R7 strobes", int'(strobes()), int'(e[5:2]));
            wait_pos(1);
            chk("R4 R5 R6 single cycle", int'(strobes()), 0);
            chk("R6 R7 bit_o", int'(bit_o), int'(e[1]));
            chk("R8 busy_o", int'(busy_o), int'(e[0]));
            wait_pos(2);
        end

        // R2 spike rejection boundary on data while clock high
        s0 = n_start; p0 = n_stop;
        sda_pulse(FILT_LEN - 1);
        chk("R2 short spike start", n_start - s0, 0);
        chk("R2 short spike stop", n_stop - p0, 0);
        sda_pulse(FILT_LEN);
        chk("R2 full pulse start", n_start - s0, 1);
        chk("R2 full pulse stop", n_stop - p0, 1);
        chk("R2 R8 busy after pulse", int'(busy_o), 0);

        // R2 spike on clock line
        f0 = n_fall;
        @(negedge clk) scl_i = 1'b0;
        repeat (FILT_LEN - 2) @(posedge clk);
        @(negedge clk) scl_i = 1'b1;
        wait_pos(3 * LAT);
        chk("R2 clock spike fall", n_fall - f0, 0);

        // R9 no hold: follows request one edge later
        oe_req_i = 1'b1;
        wait_pos(1);
        chk("R9 follow request", int'(sda_oe_o), 1);

        // R9 hold window after filtered clock fall
        scl_i = 1'b0;
        wait_pos(LAT);
        chk("R9 fall strobe", int'(scl_fall_o), 1);
        oe_req_i = 1'b0;
        wait_pos(HOLD_CYC + 1);
        chk("R9 held during window", int'(sda_oe_o), 1);
        wait_pos(1);
        chk("R9 update after window", int'(sda_oe_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule